// File: doc/BRIEF.md
# Per-Block Lock State Manager

This block holds a lock state for every erase block of a flash array and services the two-cycle command sequence that changes those states. A command write carries an 8-bit code and a block address. A setup code of 0x60 arms the sequencer. The code on the next command write picks the action, and that write's address picks the block. Each block is unlocked, locked or locked-down. An unlock command cannot release a locked-down block while the lock-down hold input is high. Only reset clears lock-down while that input stays high.

Program and erase logic asks the block whether an access is allowed. The `acc_allow` output is a combinational answer for the block on `acc_blk`. When an access is actually attempted (`acc_req`) against a block that is not unlocked, the block raises a sticky locked-block error in the status byte. A bad second code raises a sticky sequence error in the same byte. Both flags stay set until reset.

Top module: `lockmgr_top`

## Requirements
- R1: Reset leaves every block locked (state code 01), clears both error flags, and disarms the sequencer. The status byte reads 0x00 after reset.
- R2: A write of 0x60 followed by a write of 0x01 locks the block addressed by the second write. A block that was unlocked becomes 01. No other block changes.
- R3: A write of 0x60 followed by a write of 0xD0 unlocks (code 00) the addressed block when that block is not locked-down.
- R4: A write of 0x60 followed by a write of 0x2F puts the addressed block in lock-down (code 11). A block's state code is only ever 00, 01 or 11. `blk_state` bits [2i+1:2i] hold block i.
- R5: While `ld_hold` is 1, the sequence 0x60 then 0xD0 leaves a locked-down block at 11.
- R6: While `ld_hold` is 0, a locked-down block behaves as locked: the sequence 0x60 then 0xD0 sets it to 00.
- R7: The sequence 0x60 then 0x01 leaves a locked-down block at 11.
- R8: After 0x60, any second code other than 0x01, 0xD0 or 0x2F sets status bits 5 and 4 (sequence error) together and changes no block. The sequencer then disarms, so a following 0xD0 alone is ignored.
- R9: A command write that is neither 0x60 nor a second cycle after 0x60 changes no block and no flag. Without a command write, no block state changes.
- R10: An access attempt (`acc_req` high at a clock edge) on a block in state 01 or 11 sets status bit 1. An attempt on a block in state 00 leaves it clear. The state seen is the one before any command in the same cycle.
- R11: `acc_allow` is 1 exactly when the block on `acc_blk` is in state 00. It is 0 for an address at or beyond the block count.
- R12: Status bits 5, 4 and 1 stay set once set until reset. All other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_code | input | 8 | Command code |
| cmd_blk | input | BLK_W | Block address of the command write |
| ld_hold | input | 1 | 1: lock-down resists unlock; 0: lock-down acts as lock |
| acc_req | input | 1 | Program or erase attempt strobe |
| acc_blk | input | BLK_W | Block address for the query and the attempt |
| acc_allow | output | 1 | Addressed block may be programmed or erased |
| blk_state | output | 2*NBLK | Packed per-block state codes |
| status | output | 8 | Status byte: bits 5,4 sequence error; bit 1 locked-block error |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before it is checked. They also assume `acc_blk` points at an implemented block whenever `acc_req` is high, since an out-of-range attempt is refused but has no state to point at. The bench drives every input on the falling edge and only addresses blocks below the block count. It never issues an access attempt in the same cycle as a command that changes the same block, so the flag it expects does not hinge on the ordering rule in R10.

// File: rtl/lockmgr_pkg.sv
package lockmgr_pkg;
    // Per-block state encoding
    localparam logic [1:0] ST_OPEN   = 2'b00;
    localparam logic [1:0] ST_LOCKED = 2'b01;
    localparam logic [1:0] ST_DOWN   = 2'b11;

    // Command codes
    localparam logic [7:0] CODE_SETUP  = 8'h60;
    localparam logic [7:0] CODE_LOCK   = 8'h01;
    localparam logic [7:0] CODE_UNLOCK = 8'hD0;
    localparam logic [7:0] CODE_DOWN   = 8'h2F;

    // Status byte bit positions
    localparam int SB_SEQ_HI = 5;
    localparam int SB_SEQ_LO = 4;
    localparam int SB_LOCKED = 1;

    typedef enum logic [1:0] {
        ACT_LOCK   = 2'd0,
        ACT_UNLOCK = 2'd1,
        ACT_DOWN   = 2'd2,
        ACT_BAD    = 2'd3
    } lk_act_t;
endpackage

// File: rtl/lockmgr_decode.sv
module lockmgr_decode
    import lockmgr_pkg::*;
(
    input  logic [7:0] code,
    output lk_act_t    act
);
    always_comb begin
        unique case (code)
            CODE_LOCK:   act = ACT_LOCK;
            CODE_UNLOCK: act = ACT_UNLOCK;
            CODE_DOWN:   act = ACT_DOWN;
            default:     act = ACT_BAD;
        endcase
    end
endmodule

// File: rtl/lockmgr_cell.sv
module lockmgr_cell
    import lockmgr_pkg::*;
(
    input  logic [1:0] cur,
    input  logic       hit,
    input  lk_act_t    act,
    input  logic       hold,
    output logic [1:0] nxt
);
    always_comb begin
        nxt = cur;
        if (hit) begin
            unique case (act)
                ACT_LOCK:   nxt = (cur == ST_DOWN) ? ST_DOWN : ST_LOCKED;
                ACT_DOWN:   nxt = ST_DOWN;
                ACT_UNLOCK: nxt = (cur == ST_DOWN && hold) ? ST_DOWN : ST_OPEN;
                default:    nxt = cur;
            endcase
        end
    end
endmodule

// File: rtl/lockmgr_top.sv
module lockmgr_top
    import lockmgr_pkg::*;
#(
    parameter int NBLK  = 16,
    parameter int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    input  logic [BLK_W-1:0]  cmd_blk,
    input  logic              ld_hold,
    input  logic              acc_req,
    input  logic [BLK_W-1:0]  acc_blk,
    output logic              acc_allow,
    output logic [2*NBLK-1:0] blk_state,
    output logic [7:0]        status
);
    localparam int SW = 2 * NBLK;

    typedef struct packed {
        logic [NBLK-1:0][1:0] st;
        logic                 pend;
        logic                 seq_err;
        logic                 lk_err;
    } regs_t;

    regs_t q, d;
    lk_act_t act;
    logic [NBLK-1:0][1:0] cell_nxt;
    logic [1:0] acc_cur;
    logic second;

    assign second = cmd_valid && q.pend;

    lockmgr_decode u_dec (
        .code (cmd_code),
        .act  (act)
    );

    for (genvar i = 0; i < NBLK; i++) begin : g_cell
        lockmgr_cell u_cell (
            .cur  (q.st[i]),
            .hit  (second && (cmd_blk == BLK_W'(i))),
            .act  (act),
            .hold (ld_hold),
            .nxt  (cell_nxt[i])
        );
    end

    always_comb begin
        acc_cur = ST_LOCKED;
        for (int i = 0; i < NBLK; i++) begin
            if (acc_blk == BLK_W'(i)) acc_cur = q.st[i];
        end
    end

    always_comb begin
        d = q;
        d.st = cell_nxt;
        if (cmd_valid) begin
            if (q.pend) begin
                d.pend = 1'b0;
                if (act == ACT_BAD) d.seq_err = 1'b1;
            end else begin
                d.pend = (cmd_code == CODE_SETUP);
            end
        end
        if (acc_req && acc_cur != ST_OPEN) d.lk_err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBLK; i++) q.st[i] <= ST_LOCKED;
            q.pend    <= 1'b0;
            q.seq_err <= 1'b0;
            q.lk_err  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign acc_allow = (acc_cur == ST_OPEN);
    assign blk_state = SW'(q.st);

    always_comb begin
        status = 8'h00;
        status[SB_SEQ_HI] = q.seq_err;
        status[SB_SEQ_LO] = q.seq_err;
        status[SB_LOCKED] = q.lk_err;
    end
endmodule

// File: rtl/lockmgr_chk.sv
module lockmgr_chk #(
    parameter int NBLK  = 16,
    parameter int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              ld_hold,
    input logic              acc_req,
    input logic              acc_allow,
    input logic [2*NBLK-1:0] blk_state,
    input logic [7:0]        status
);
    for (genvar i = 0; i < NBLK; i++) begin : g_blk
        assert_legal_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
            blk_state[2*i+1 -: 2] != 2'b10);
        assert_down_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (blk_state[2*i+1 -: 2] == 2'b11 && ld_hold) |=> blk_state[2*i+1 -: 2] == 2'b11);
    end

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(blk_state));

    assert_seq_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        status[5] == status[4]);

    assert_refuse_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_allow) |=> status[1]);

    assert_seq_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        status[5] |=> status[5]);

    assert_lk_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |=> status[1]);

    assert_spare_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (status & 8'hCD) == 8'h00);
endmodule

bind lockmgr_top lockmgr_chk #(.NBLK(NBLK), .BLK_W(BLK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .ld_hold   (ld_hold),
    .acc_req   (acc_req),
    .acc_allow (acc_allow),
    .blk_state (blk_state),
    .status    (status)
);

// File: tb/lockmgr_top_bench.sv
module lockmgr_top_bench;
    localparam int NBLK  = 16;
    localparam int BLK_W = 4;
    localparam int SW    = 2 * NBLK;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [7:0] cmd_code = 8'h00;
    logic [BLK_W-1:0] cmd_blk = '0;
    logic ld_hold = 1'b1;
    logic acc_req = 1'b0;
    logic [BLK_W-1:0] acc_blk = '0;
    logic acc_allow;
    logic [SW-1:0] blk_state;
    logic [7:0] status;

    always #10 clk = ~clk;

    lockmgr_top #(.NBLK(NBLK), .BLK_W(BLK_W)) u_lockmgr_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_blk   (cmd_blk),
        .ld_hold   (ld_hold),
        .acc_req   (acc_req),
        .acc_blk   (acc_blk),
        .acc_allow (acc_allow),
        .blk_state (blk_state),
        .status    (status)
    );

    typedef struct packed {
        logic          is_query;
        logic [SW-1:0] st;
        logic [7:0]    sb;
        logic          allow;
        logic [31:0]   tag;
    } item_t;

    item_t sbq[$];
    int checks = 0;
    int fails = 0;

    // Reference model
    logic [1:0] m_st [NBLK];
    logic m_pend, m_seq, m_lk;

    function automatic logic [SW-1:0] m_vec();
        logic [SW-1:0] v;
        for (int i = 0; i < NBLK; i++) v[2*i +: 2] = m_st[i];
        return v;
    endfunction

    function automatic logic [7:0] m_sb();
        return {2'b00, m_seq, m_seq, 2'b00, m_lk, 1'b0};
    endfunction

    task automatic push_state(input logic [31:0] tag);
        item_t it;
        it.is_query = 1'b0; it.st = m_vec(); it.sb = m_sb(); it.allow = 1'b0; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic do_reset(input logic [31:0] tag);
        rst_n = 1'b0;
        @(posedge clk); #1;
        for (int i = 0; i < NBLK; i++) m_st[i] = 2'b01;
        m_pend = 1'b0; m_seq = 1'b0; m_lk = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        push_state(tag);
        @(posedge clk); #1;
        @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] code, input int blk, input logic [31:0] tag);
        cmd_valid = 1'b1; cmd_code = code; cmd_blk = BLK_W'(blk);
        @(posedge clk); #1;
        if (m_pend) begin
            m_pend = 1'b0;
            case (code)
                8'h01: if (m_st[blk] != 2'b11) m_st[blk] = 2'b01;
                8'h2F: m_st[blk] = 2'b11;
                8'hD0: if (!(m_st[blk] == 2'b11 && ld_hold)) m_st[blk] = 2'b00;
                default: m_seq = 1'b1;
            endcase
        end else begin
            m_pend = (code == 8'h60);
        end
        push_state(tag);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic query(input int blk, input logic [31:0] tag);
        item_t it;
        acc_blk = BLK_W'(blk);
        it.is_query = 1'b1; it.st = '0; it.sb = '0; it.allow = (m_st[blk] == 2'b00); it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
    endtask

    task automatic attempt(input int blk, input logic [31:0] tag);
        acc_blk = BLK_W'(blk); acc_req = 1'b1;
        @(posedge clk); #1;
        if (m_st[blk] != 2'b00) m_lk = 1'b1;
        push_state(tag);
        @(negedge clk);
        acc_req = 1'b0;
    endtask

    task automatic idle(input logic [31:0] tag);
        @(posedge clk); #1;
        push_state(tag);
        @(negedge clk);
    endtask

    // Monitor: compare 15 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #15;
            while (sbq.size() > 0) begin
                item_t it;
                it = sbq.pop_front();
                checks++;
                if (it.is_query) begin
                    if (acc_allow !== it.allow) begin
                        fails++;
                        $display("FAIL %s acc_allow actual=%b expected=%b", it.tag, acc_allow, it.allow);
                    end
                end else if (blk_state !== it.st || status !== it.sb) begin
                    fails++;
                    $display("FAIL %s state/status actual=%h/%h expected=%h/%h",
                             it.tag, blk_state, status, it.st, it.sb);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset("R1  ");
        query(0, "R11 ");
        cmd(8'h60, 3, "R3  "); cmd(8'hD0, 3, "R3  ");
        query(3, "R11 "); query(4, "R11 ");
        attempt(3, "R10 ");
        cmd(8'h60, 5, "R4  "); cmd(8'h2F, 5, "R4  ");
        query(5, "R11 ");
        cmd(8'h60, 5, "R5  "); cmd(8'hD0, 5, "R5  ");
        cmd(8'h60, 5, "R7  "); cmd(8'h01, 5, "R7  ");
        cmd(8'h60, 3, "R2  "); cmd(8'h01, 3, "R2  ");
        cmd(8'h01, 7, "R9  "); cmd(8'hD0, 7, "R9  ");
        cmd(8'h60, 7, "R8  "); cmd(8'h40, 7, "R8  ");
        cmd(8'hD0, 7, "R8  ");
        attempt(7, "R10 ");
        idle("R12 "); idle("R12 ");
        cmd(8'h60, 12, "R3  "); cmd(8'hD0, 12, "R3  ");
        attempt(12, "R12 ");
        do_reset("R1  ");
        ld_hold = 1'b0;
        cmd(8'h60, 9, "R4  "); cmd(8'h2F, 9, "R4  ");
        cmd(8'h60, 9, "R6  "); cmd(8'hD0, 9, "R6  ");
        query(9, "R11 ");
        attempt(9, "R10 ");
        attempt(15, "R10 ");
        idle("R12 ");
        @(posedge clk); @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule